// File: doc/BRIEF.md
# Video memory data port with read-ahead buffer

This block is the processor's single byte-wide window into a 16 KiB video memory space and a small colour-palette store. It keeps its own 15-bit access pointer. Each accepted access moves one byte and then advances the pointer by 1 or by 32. Which stride applies is chosen by a control pin that is sampled at acceptance. The 14 low pointer bits form the video address. Addresses from 0x3F00 to 0x3FFF belong to the palette, and all lower addresses belong to video RAM.

Reads from video RAM are pipelined through a one-byte read-ahead buffer. A read hands back the byte that the previous read fetched, and it starts a fetch at the current address to refill the buffer. Palette reads made while rendering is idle skip that buffer. They return the palette entry, with its top two bits replaced by the I/O data latch. The I/O data latch is the last byte to cross the port in either direction. Palette-region reads still refill the buffer from the video RAM that lies under the palette range.

Requests enter on a valid/ready channel. Only reads produce an item on the response valid/ready channel. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` stays low while a read response is waiting or a buffer fill is pending, so the response channel's back-pressure stalls new requests. Once `rsp_valid` rises, `rsp_rdata` holds steady until the cycle in which `rsp_ready` is high.

Top module: `vdp_data_port`

## Requirements
- R1: After reset the pointer, read buffer and I/O latch are all zero, `rsp_valid` is 0 and `req_ready` is 1, so the first read returns 0x00.
- R2: In the cycle a request is accepted, any video RAM access it makes uses `vram_addr` equal to pointer bits [13:0].
- R3: A read at a video address below 0x3F00 returns the buffer contents. The buffer then loads `vram_rdata` from the fetch at the current address, one cycle after `vram_req`.
- R4: A read at a video address in 0x3F00..0x3FFF with `rendering` low returns bits [7:6] from the I/O latch and bits [5:0] from `pal_rdata`, with `pal_idx` equal to address bits [4:0].
- R5: A palette-region read with `rendering` high returns the buffer contents, exactly like a video RAM read.
- R6: Every accepted access adds 32 to the pointer if `stride_big` is 1 at acceptance, and 1 otherwise. The pointer wraps modulo 2^15.
- R7: A write in the palette region pulses `pal_we` with `pal_idx` = address[4:0] and does not touch video RAM, regardless of `rendering`. A write below 0x3F00 pulses `vram_req` with `vram_we` = 1 and does not pulse `pal_we`.
- R8: The I/O latch takes the returned byte after a read and the written byte after a write.
- R9: `req_ready` is low whenever `rsp_valid` is high. `rsp_rdata` stays stable while `rsp_valid` is high and `rsp_ready` is low. Writes produce no response.
- R10: A palette-region read still fetches video RAM at its address, so the next buffered read returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| stride_big | input | 1 | Pointer step 32 when 1, else 1 |
| rendering | input | 1 | Rendering active; disables palette read bypass |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the read result |
| rsp_rdata | output | 8 | Read result |
| vram_req | output | 1 | Video RAM access strobe |
| vram_we | output | 1 | Video RAM write enable (with vram_req) |
| vram_addr | output | 14 | Video RAM address |
| vram_wdata | output | 8 | Video RAM write byte |
| vram_rdata | input | 8 | Video RAM read byte, valid one cycle after a read strobe |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 5 | Palette entry index |
| pal_wdata | output | 8 | Palette write byte |
| pal_rdata | input | 8 | Palette entry at pal_idx, combinational |

## Verification
Two functions can fall in the same cycle: the buffer refill from video RAM and the presentation of the previous read's result on the response channel. Both happen in the cycle after a read is accepted. The bench provokes this with reads issued back to back as soon as `req_ready` returns. Its scoreboard requires each result to be the byte fetched by the read before, never the byte landing in that same cycle. A second same-cycle pairing is the I/O latch update with a palette read's use of it. The bench checks this by alternating writes and palette reads with known high bits, while the response channel is throttled.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  // access classification made at acceptance
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/vdp_addr_step.sv
module vdp_addr_step #(
  parameter int ADDR_W     = 15,
  parameter int BIG_STRIDE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              big,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W-1:0] INC_SMALL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] INC_BIG   = ADDR_W'(BIG_STRIDE);

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr_q <= '0;
    else if (step)
      addr_q <= addr_q + (big ? INC_BIG : INC_SMALL);
  end
endmodule

// File: rtl/vdp_region_decode.sv
module vdp_region_decode #(
  parameter int ADDR_W    = 15,
  parameter int VADDR_W   = 14,
  parameter int PAL_IDX_W = 5,
  parameter int PAL_BASE  = 'h3F00
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [VADDR_W-1:0]   vaddr,
  output logic                 in_pal,
  output logic [PAL_IDX_W-1:0] pal_idx
);
  localparam logic [VADDR_W-1:0] BASE = VADDR_W'(PAL_BASE);

  assign vaddr   = addr[VADDR_W-1:0];
  assign in_pal  = (vaddr >= BASE);
  assign pal_idx = vaddr[PAL_IDX_W-1:0];
endmodule

// File: rtl/vdp_read_path.sv
module vdp_read_path #(
  parameter int DATA_W    = 8,
  parameter int OPEN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              wr_go,
  input  logic              pal_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pal_rdata,
  input  logic [DATA_W-1:0] vram_rdata,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_busy,
  output logic [DATA_W-1:0] io_q,
  output logic [DATA_W-1:0] buf_q
);
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_value;

  // upper OPEN_BITS come from the I/O latch, the rest from the palette
  for (genvar b = 0; b < DATA_W; b++) begin : g_merge
    if (b >= DATA_W - OPEN_BITS) begin : g_io
      assign merged[b] = io_q[b];
    end else begin : g_pal
      assign merged[b] = pal_rdata[b];
    end
  end

  assign rd_value = pal_sel ? merged : buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      fill_busy <= 1'b0;
      io_q      <= '0;
      buf_q     <= '0;
    end else begin
      if (fill_busy) begin
        buf_q     <= vram_rdata;
        fill_busy <= 1'b0;
      end
      if (rsp_valid && rsp_ready)
        rsp_valid <= 1'b0;
      if (rd_go) begin
        rsp_data  <= rd_value;
        rsp_valid <= 1'b1;
        io_q      <= rd_value;
        fill_busy <= 1'b1;
      end else if (wr_go) begin
        io_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/vdp_data_port.sv
module vdp_data_port #(
  parameter int ADDR_W     = 15,
  parameter int VADDR_W    = 14,
  parameter int DATA_W     = 8,
  parameter int PAL_IDX_W  = 5,
  parameter int PAL_BASE   = 'h3F00,
  parameter int BIG_STRIDE = 32,
  parameter int OPEN_BITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 stride_big,
  input  logic                 rendering,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 vram_req,
  output logic                 vram_we,
  output logic [VADDR_W-1:0]   vram_addr,
  output logic [DATA_W-1:0]    vram_wdata,
  input  logic [DATA_W-1:0]    vram_rdata,
  output logic                 pal_we,
  output logic [PAL_IDX_W-1:0] pal_idx,
  output logic [DATA_W-1:0]    pal_wdata,
  input  logic [DATA_W-1:0]    pal_rdata
);
  import vdp_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic              in_pal;
  logic              fill_busy;
  logic [DATA_W-1:0] io_q;
  logic [DATA_W-1:0] buf_q;
  logic              accept;
  acc_kind_e         kind;

  assign req_ready = !rsp_valid && !fill_busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    kind = ACC_IDLE;
    if (accept) kind = req_write ? ACC_WRITE : ACC_READ;
  end

  vdp_addr_step #(.ADDR_W(ADDR_W), .BIG_STRIDE(BIG_STRIDE)) u_step (
    .clk(clk), .rst_n(rst_n), .step(accept), .big(stride_big), .addr_q(addr_q)
  );

  vdp_region_decode #(
    .ADDR_W(ADDR_W), .VADDR_W(VADDR_W), .PAL_IDX_W(PAL_IDX_W), .PAL_BASE(PAL_BASE)
  ) u_dec (
    .addr(addr_q), .vaddr(vram_addr), .in_pal(in_pal), .pal_idx(pal_idx)
  );

  vdp_read_path #(.DATA_W(DATA_W), .OPEN_BITS(OPEN_BITS)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_go(kind == ACC_READ), .wr_go(kind == ACC_WRITE),
    .pal_sel(in_pal && !rendering),
    .wdata(req_wdata), .pal_rdata(pal_rdata), .vram_rdata(vram_rdata),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_rdata),
    .fill_busy(fill_busy), .io_q(io_q), .buf_q(buf_q)
  );

  // reads always fetch video RAM (buffer refill); palette writes skip it
  assign vram_req   = (kind == ACC_READ) || ((kind == ACC_WRITE) && !in_pal);
  assign vram_we    = (kind == ACC_WRITE);
  assign vram_wdata = req_wdata;
  assign pal_we     = (kind == ACC_WRITE) && in_pal;
  assign pal_wdata  = req_wdata;
endmodule

// File: rtl/vdp_data_port_chk.sv
module vdp_data_port_chk #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int BIG_STRIDE = 32,
  parameter int OPEN_BITS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input logic              stride_big,
  input logic              rendering,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              vram_req,
  input logic              pal_we,
  input logic              in_pal,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] io_q
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_no_accept_while_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_read_gives_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  p_write_no_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_valid);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (addr_q == $past(addr_q) + ($past(stride_big) ? ADDR_W'(BIG_STRIDE) : ADDR_W'(1))));

  p_pal_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> !vram_req);

  p_io_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (io_q == $past(req_wdata)));

  p_pal_open_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && in_pal && !rendering) |=>
      (rsp_rdata[DATA_W-1 -: OPEN_BITS] == $past(io_q[DATA_W-1 -: OPEN_BITS])));
endmodule

bind vdp_data_port vdp_data_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIG_STRIDE(BIG_STRIDE), .OPEN_BITS(OPEN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_wdata(req_wdata), .stride_big(stride_big),
  .rendering(rendering), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .vram_req(vram_req), .pal_we(pal_we), .in_pal(in_pal),
  .addr_q(addr_q), .io_q(io_q)
);

// File: tb/vdp_data_port_bench.sv
module vdp_data_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, stride_big = 1'b0, rendering = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_ready = 1'b0;
  logic       req_ready, rsp_valid, vram_req, vram_we, pal_we;
  logic [7:0] rsp_rdata, vram_wdata, pal_wdata, pal_rdata;
  logic [7:0] vram_rdata = 8'h00;
  logic [13:0] vram_addr;
  logic [4:0]  pal_idx;

  always #2 clk = ~clk;  // 250 MHz

  vdp_data_port u_vdp_data_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wdata(req_wdata), .stride_big(stride_big),
    .rendering(rendering), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .vram_req(vram_req), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
    .pal_we(pal_we), .pal_idx(pal_idx), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata)
  );

  int errors = 0, checks = 0;
  logic [7:0] vmem [int];
  logic [7:0] pal_mem [32];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  function automatic logic [7:0] seed_byte(int a);
    return 8'((a * 7) ^ (a >> 6) ^ 8'h5C);
  endfunction
  function automatic logic [7:0] vget(int a);
    return vmem.exists(a) ? vmem[a] : seed_byte(a);
  endfunction

  // memory models
  always @(posedge clk) begin
    if (vram_req) begin
      if (vram_we) vmem[int'(vram_addr)] = vram_wdata;
      else vram_rdata <= vget(int'(vram_addr));
    end
    if (pal_we) pal_mem[pal_idx] <= pal_wdata;
  end
  assign pal_rdata = pal_mem[pal_idx];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  logic [14:0] m_addr = '0;
  logic [7:0]  m_buf = '0, m_io = '0;
  bit          m_first = 1'b1, m_buf_pal = 1'b0;

  task automatic access(input bit wr, input logic [7:0] d, input bit big, input bit rend);
    logic [13:0] va;
    bit ispal;
    logic [7:0] e;
    string t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = d; stride_big = big; rendering = rend;
    #1;
    va = m_addr[13:0];
    ispal = (va >= 14'h3F00);
    chk(vram_req == !(wr && ispal), "R7 vram_req", vram_req, !(wr && ispal));
    chk(pal_we == (wr && ispal), "R7 pal_we", pal_we, wr && ispal);
    if (vram_req) chk(vram_addr == va, "R2/R6 vram_addr", vram_addr, va);
    if (ispal) chk(pal_idx == va[4:0], "R4/R7 pal_idx", pal_idx, va[4:0]);
    if (wr) begin
      if (ispal) pal_mem_shadow[va[4:0]] = d; else vmem_shadow_note = 1'b1;
      m_io = d;
    end else begin
      if (ispal && !rend) begin
        e = {m_io[7:6], pal_mem_shadow[va[4:0]][5:0]}; t = "R4 palette read";
      end else begin
        e = m_buf;
        t = m_first ? "R1 reset buffer" : (m_buf_pal ? "R10 fill under palette"
            : (ispal ? "R5 rendering read" : "R3 buffered read"));
      end
      m_first = 1'b0;
      m_buf = vget(int'(va));
      m_buf_pal = ispal;
      m_io = e;
      exp_q.push_back(e); tag_q.push_back(t);
    end
    m_addr = m_addr + (big ? 15'd32 : 15'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  logic [7:0] pal_mem_shadow [32];
  bit vmem_shadow_note = 1'b0;

  // monitor: drives rsp_ready, pops the scoreboard on handshake
  int cyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      rsp_ready = (cyc % 7) >= 2;
      if (rsp_valid) begin
        chk(!req_ready, "R9 ready low during rsp", req_ready, 0);
        if (rsp_ready) begin
          if (exp_q.size() == 0) chk(1'b0, "R9 unexpected response", rsp_rdata, 0);
          else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(rsp_rdata == e, t, rsp_rdata, e);
          end
        end
      end
    end
  end

  task automatic walk_to(input logic [14:0] target);
    int k = 0;
    while (m_addr != target) begin
      automatic bit big = (15'(target - m_addr) >= 15'd32);
      access(k % 3 == 0 ? 1'b0 : 1'b1, 8'(k * 13 + 1), big, k[0]);
      k++;
    end
  endtask

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < 32; i++) begin pal_mem[i] = 8'h00; pal_mem_shadow[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    access(1'b0, 8'h00, 1'b0, 1'b0);   // R1: returns 0x00
    access(1'b0, 8'h00, 1'b0, 1'b0);   // R3: returns byte at 0
    access(1'b1, 8'h5A, 1'b0, 1'b0);   // R7: video RAM write
    access(1'b0, 8'h00, 1'b0, 1'b0);   // back-to-back buffered reads
    access(1'b0, 8'h00, 1'b0, 1'b0);
    walk_to(15'h3F00);                  // R6 stride mix
    for (int i = 0; i < 32; i++)        // R7 palette writes, rendering mixed
      access(1'b1, 8'(8'h40 + i * 5), 1'b0, i[0]);
    walk_to(15'h7F00);                  // crosses 0x4000: R2 masking
    access(1'b1, 8'hBF, 1'b0, 1'b1);    // palette write while rendering, io=BF (R8)
    access(1'b0, 8'h00, 1'b0, 1'b0);    // R4 merged read
    access(1'b0, 8'h00, 1'b0, 1'b1);    // R5 rendering: buffered
    access(1'b0, 8'h00, 1'b0, 1'b0);    // R4 again, io from previous result
    access(1'b0, 8'h00, 1'b0, 1'b1);    // R10 byte fetched under palette
    access(1'b1, 8'h3F, 1'b0, 1'b0);    // R8 io=3F
    access(1'b0, 8'h00, 1'b0, 1'b0);    // R4 top bits 00
    access(1'b1, 8'hC1, 1'b1, 1'b0);    // stride 32 in palette region
    for (int i = 0; i < 6; i++) access(1'b0, 8'h00, 1'b0, i[1]); // mirrored index
    walk_to(15'h0004);                  // wrap through 0x7FFF
    access(1'b0, 8'h00, 1'b0, 1'b0);
    access(1'b0, 8'h00, 1'b0, 1'b0);
    while (exp_q.size() != 0 || rsp_valid) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) chk(1'b0, "watchdog", n, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule